// File: doc/BRIEF.md
# Multi-Lane Frame Readout Buffer

This block gathers one image frame from a detector module whose readout chips push pixel data over many parallel serial lanes during a short readout burst. Every lane shifts in fixed-width pixel words, most significant bit first. All lanes run in lockstep from a shared bit strobe. A single marker input announces the start of each frame. Lane k carries pixels k, k+NUM_LANES, k+2·NUM_LANES and so on. The block writes the lanes side by side into one row of an on-chip frame store, so a single ascending read pointer puts the frame back in pixel order.

The store holds two frame banks that are used in turn. While the slow output stream drains one completed bank through a valid/ready word interface, the next burst can fill the other bank. The output marks the first word of a frame with a start flag and the last word with an end flag. A bank becomes free again only once its last word has been accepted. If a frame marker arrives while the bank due to be filled still holds an undrained frame, that frame is discarded and a one-cycle drop flag is raised.

NUM_LANES and WORDS_PER_LANE must be powers of two, and WORDS_PER_LANE must be at least 2. One frame is NUM_LANES·WORDS_PER_LANE pixels of PIX_W bits.

Top module: `lane_frame_buffer`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof and frame_dropped are all low.
- R2: Each lane takes one bit per cycle in which in_valid is high, most significant bit first. After PIX_W such bits it forms one pixel word. Cycles with in_valid low neither add bits nor disturb the lane's progress.
- R3: The n-th word (counting from 0) of lane k is pixel n·NUM_LANES+k. A drained frame leaves in ascending pixel order, pixel 0 first.
- R4: A cycle with frame_start high clears every lane's bit count and the frame's word count. Any partial frame in progress is abandoned. Bits presented in that same cycle are ignored.
- R5: A frame is complete after WORDS_PER_LANE words per lane. Further bits are ignored until the next frame_start.
- R6: Frames go to bank 0 and bank 1 alternately, and are drained in the order they completed. A frame can fill one bank while the other bank is being drained.
- R7: If frame_start arrives while the bank due to be filled still holds a frame, frame_dropped is high for exactly one cycle, in the cycle after frame_start. The new frame is discarded, and the frames already stored come out unchanged.
- R8: out_sof is high only with the first word of a frame and out_eof only with the last. The two are never high together. The word after an accepted last word, if valid, carries out_sof.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sof and out_eof hold their values.
- R10: A bank is released only in the cycle after its last word is accepted. A frame_start before then, while the other bank is also occupied, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Frame marker, one cycle before the first bits |
| in_valid | input | 1 | Shared bit strobe for all lanes |
| lane_bits | input | NUM_LANES | One serial bit per lane |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | A drained word is presented |
| out_data | output | PIX_W | Pixel value |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| frame_dropped | output | 1 | One-cycle pulse: an incoming frame was discarded |

## Verification
The assertions assume that out_ready is driven cleanly at the clock edges. They also assume that frame_start is a single-cycle marker and that no bits belonging to the frame are presented in that cycle. The stability checks rely on the store never writing into a bank that is still draining. The stimulus keeps to these assumptions: it drives every input just after the rising edge, sends garbage bits only in frame_start cycles or outside a frame (where R4 and R5 say they are ignored), and holds each frame marker for exactly one cycle.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  typedef logic bank_sel_t;

  function automatic bank_sel_t other_bank(bank_sel_t b);
    return ~b;
  endfunction
endpackage

// File: rtl/lfb_rst_sync.sv
module lfb_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lfb_lane_deser.sv
module lfb_lane_deser #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_en,
  input  logic             bit_in,
  output logic [PIX_W-1:0] word,
  output logic             word_done
);
  localparam int CNT_W = $clog2(PIX_W);

  logic [PIX_W-2:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign word = {shift_q, bit_in};

  always_comb begin
    shift_d   = shift_q;
    cnt_d     = cnt_q;
    word_done = 1'b0;
    if (clear) begin
      cnt_d = '0;
    end else if (bit_en) begin
      shift_d = word[PIX_W-2:0];
      if (cnt_q == CNT_W'(PIX_W-1)) begin
        cnt_d     = '0;
        word_done = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/lfb_frame_store.sv
module lfb_frame_store #(
  parameter int NUM_LANES      = 32,
  parameter int PIX_W          = 8,
  parameter int WORDS_PER_LANE = 4,
  localparam int LINE_W = NUM_LANES * PIX_W,
  localparam int ROW_W  = $clog2(WORDS_PER_LANE),
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  lfb_pkg::bank_sel_t wr_bank,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [LINE_W-1:0] wr_line,
  input  lfb_pkg::bank_sel_t rd_bank,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [PIX_W-1:0]  rd_pixel
);
  logic [LINE_W-1:0] mem_q [2][WORDS_PER_LANE];
  logic [LINE_W-1:0] rd_line;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_bank][wr_row] <= wr_line;
  end

  assign rd_line  = mem_q[rd_bank][rd_row];
  assign rd_pixel = rd_line[rd_lane*PIX_W +: PIX_W];
endmodule

// File: rtl/lfb_drain.sv
module lfb_drain #(
  parameter int FRAME_PIX = 128,
  localparam int ADDR_W = $clog2(FRAME_PIX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         bank_full,
  input  logic               out_ready,
  output lfb_pkg::bank_sel_t rd_bank,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               out_valid,
  output logic               out_sof,
  output logic               out_eof,
  output logic               release_bank
);
  lfb_pkg::bank_sel_t bank_q, bank_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               last_word;

  assign rd_bank   = bank_q;
  assign rd_addr   = addr_q;
  assign out_valid = bank_full[bank_q];
  assign last_word = (addr_q == ADDR_W'(FRAME_PIX-1));
  assign out_sof   = out_valid && (addr_q == '0);
  assign out_eof   = out_valid && last_word;

  always_comb begin
    bank_d       = bank_q;
    addr_d       = addr_q;
    release_bank = 1'b0;
    if (out_valid && out_ready) begin
      if (last_word) begin
        addr_d       = '0;
        bank_d       = lfb_pkg::other_bank(bank_q);
        release_bank = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      addr_q <= '0;
    end else begin
      bank_q <= bank_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/lane_frame_buffer.sv
module lane_frame_buffer #(
  parameter int NUM_LANES      = 32,
  parameter int PIX_W          = 8,
  parameter int WORDS_PER_LANE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 in_valid,
  input  logic [NUM_LANES-1:0] lane_bits,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [PIX_W-1:0]     out_data,
  output logic                 out_sof,
  output logic                 out_eof,
  output logic                 frame_dropped
);
  import lfb_pkg::*;

  localparam int FRAME_PIX = NUM_LANES * WORDS_PER_LANE;
  localparam int LINE_W    = NUM_LANES * PIX_W;
  localparam int ROW_W     = $clog2(WORDS_PER_LANE);
  localparam int LANE_W    = $clog2(NUM_LANES);
  localparam int ADDR_W    = ROW_W + LANE_W;

  logic rst_n_s;

  lfb_rst_sync u_rst (.clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s));

  // Fill state
  logic             filling_q, filling_d;
  bank_sel_t        wr_bank_q, wr_bank_d;
  logic [ROW_W-1:0] wr_row_q, wr_row_d;
  logic [1:0]       full_q, full_d;
  logic             drop_q, drop_d;

  logic                 lane_en;
  logic [NUM_LANES-1:0] lane_done;
  logic [LINE_W-1:0]    lane_line;
  logic                 row_strobe;

  bank_sel_t         rd_bank;
  logic [ADDR_W-1:0] rd_addr;
  logic              release_bank;

  assign lane_en = in_valid && filling_q && !frame_start;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    lfb_lane_deser #(.PIX_W(PIX_W)) u_deser (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .clear     (frame_start),
      .bit_en    (lane_en),
      .bit_in    (lane_bits[k]),
      .word      (lane_line[k*PIX_W +: PIX_W]),
      .word_done (lane_done[k])
    );
  end

  // All lanes share one strobe, so they finish a word together.
  assign row_strobe = &lane_done;

  always_comb begin
    filling_d = filling_q;
    wr_bank_d = wr_bank_q;
    wr_row_d  = wr_row_q;
    full_d    = full_q;
    drop_d    = 1'b0;
    if (release_bank) full_d[rd_bank] = 1'b0;
    if (frame_start) begin
      wr_row_d = '0;
      if (full_q[wr_bank_q]) begin
        filling_d = 1'b0;
        drop_d    = 1'b1;
      end else begin
        filling_d = 1'b1;
      end
    end else if (row_strobe) begin
      if (wr_row_q == ROW_W'(WORDS_PER_LANE-1)) begin
        full_d[wr_bank_q] = 1'b1;
        filling_d         = 1'b0;
        wr_bank_d         = other_bank(wr_bank_q);
        wr_row_d          = '0;
      end else begin
        wr_row_d = wr_row_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      filling_q <= 1'b0;
      wr_bank_q <= 1'b0;
      wr_row_q  <= '0;
      full_q    <= 2'b00;
      drop_q    <= 1'b0;
    end else begin
      filling_q <= filling_d;
      wr_bank_q <= wr_bank_d;
      wr_row_q  <= wr_row_d;
      full_q    <= full_d;
      drop_q    <= drop_d;
    end
  end

  assign frame_dropped = drop_q;

  lfb_frame_store #(
    .NUM_LANES(NUM_LANES), .PIX_W(PIX_W), .WORDS_PER_LANE(WORDS_PER_LANE)
  ) u_store (
    .clk      (clk),
    .wr_en    (row_strobe),
    .wr_bank  (wr_bank_q),
    .wr_row   (wr_row_q),
    .wr_line  (lane_line),
    .rd_bank  (rd_bank),
    .rd_row   (rd_addr[ADDR_W-1:LANE_W]),
    .rd_lane  (rd_addr[LANE_W-1:0]),
    .rd_pixel (out_data)
  );

  lfb_drain #(.FRAME_PIX(FRAME_PIX)) u_drain (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .bank_full    (full_q),
    .out_ready    (out_ready),
    .rd_bank      (rd_bank),
    .rd_addr      (rd_addr),
    .out_valid    (out_valid),
    .out_sof      (out_sof),
    .out_eof      (out_eof),
    .release_bank (release_bank)
  );
endmodule

// File: rtl/lane_frame_buffer_chk.sv
module lane_frame_buffer_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             out_ready,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sof,
  input logic             out_eof,
  input logic             frame_dropped
);
  AST_DROP_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame_dropped |-> $past(frame_start)); // R7

  AST_DROP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_dropped |=> !frame_dropped); // R7

  AST_MARKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_sof && out_eof)); // R8

  AST_MARKS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eof) |-> out_valid); // R8

  AST_SOF_FOLLOWS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eof) |=> (!out_valid || out_sof)); // R8

  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R9

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_sof) && $stable(out_eof))); // R9
endmodule

bind lane_frame_buffer lane_frame_buffer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .out_ready     (out_ready),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .out_sof       (out_sof),
  .out_eof       (out_eof),
  .frame_dropped (frame_dropped)
);

// File: tb/lane_frame_buffer_test.sv
`timescale 1ns/1ps
module lane_frame_buffer_test;
  localparam int LANES = 32;
  localparam int PW    = 8;
  localparam int WPL   = 4;
  localparam int FP    = LANES * WPL;

  logic             clk;
  logic             rst_n;
  logic             frame_start;
  logic             in_valid;
  logic [LANES-1:0] lane_bits;
  logic             out_ready;
  logic             out_valid;
  logic [PW-1:0]    out_data;
  logic             out_sof;
  logic             out_eof;
  logic             frame_dropped;

  lane_frame_buffer #(.NUM_LANES(LANES), .PIX_W(PW), .WORDS_PER_LANE(WPL)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .lane_bits(lane_bits), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .frame_dropped(frame_dropped)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int rx_cnt = 0;
  int drop_cnt = 0;
  int ready_mode = 0;
  int cyc = 0;
  bit finished = 0;
  logic [PW-1:0] rx_data [0:1023];
  bit            rx_sof  [0:1023];
  bit            rx_eof  [0:1023];

  function automatic logic [PW-1:0] pix(int f, int p);
    return PW'((f * 37 + p * 5 + 3) ^ (p >> 3));
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Collector, sampled away from the rising edge
  always @(negedge clk) begin
    if (out_valid && out_ready && rx_cnt < 1024) begin
      rx_data[rx_cnt] = out_data;
      rx_sof[rx_cnt]  = out_sof;
      rx_eof[rx_cnt]  = out_eof;
      rx_cnt++;
    end
    if (frame_dropped) drop_cnt++;
  end

  // Ready pattern generator
  always @(posedge clk) begin
    cyc++;
    #1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 0;
      2: out_ready = 1'b0;
      default: ;
    endcase
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Frame marker (with garbage bits that must be ignored, R4), then rows of bits
  task automatic send_frame(int f, int rows, bit gaps);
    @(posedge clk); #1;
    frame_start = 1'b1;
    in_valid    = 1'b1;
    lane_bits   = '1;
    tick();
    frame_start = 1'b0;
    for (int r = 0; r < rows; r++) begin
      for (int b = 0; b < PW; b++) begin
        if (gaps && (b % 3 == 1)) begin
          in_valid  = 1'b0;
          lane_bits = $urandom;
          tick();
        end
        in_valid = 1'b1;
        for (int k = 0; k < LANES; k++) lane_bits[k] = pix(f, r * LANES + k)[PW-1-b];
        tick();
      end
    end
    in_valid  = 1'b0;
    lane_bits = '0;
  endtask

  task automatic wait_words(int n);
    int t;
    t = 0;
    while (rx_cnt < n && t < 5000) begin
      tick();
      t++;
    end
    check(rx_cnt >= n, "R6", "words drained before timeout", rx_cnt, n);
  endtask

  task automatic check_frame(int f, int base);
    for (int i = 0; i < FP; i++) begin
      check(rx_data[base+i] == pix(f, i), "R3", $sformatf("frame %0d pixel %0d data", f, i),
            rx_data[base+i], pix(f, i));
      check(rx_sof[base+i] == (i == 0), "R8", $sformatf("frame %0d pixel %0d sof", f, i),
            rx_sof[base+i], i == 0);
      check(rx_eof[base+i] == (i == FP-1), "R8", $sformatf("frame %0d pixel %0d eof", f, i),
            rx_eof[base+i], i == FP-1);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    check(frame_dropped == 1'b0, "R1", "frame_dropped after reset", frame_dropped, 0);
    check(out_sof == 1'b0 && out_eof == 1'b0, "R1", "markers after reset", out_sof + out_eof, 0);
  endtask

  // R2, R3, R8: one frame, free-flowing output
  task automatic test_single();
    rx_cnt = 0; drop_cnt = 0; ready_mode = 0;
    send_frame(1, WPL, 0);
    wait_words(FP);
    check_frame(1, 0);
    repeat (40) tick();
    check(rx_cnt == FP, "R5", "no extra words after frame", rx_cnt, FP);
  endtask

  // R2, R6: bit gaps, backpressure, second fill overlapping drain
  task automatic test_overlap();
    rx_cnt = 0; drop_cnt = 0; ready_mode = 1;
    send_frame(2, WPL, 1);
    send_frame(3, WPL, 1);
    wait_words(2 * FP);
    check_frame(2, 0);
    check_frame(3, FP);
    check(drop_cnt == 0, "R6", "no drop while other bank free", drop_cnt, 0);
  endtask

  // R7, R9: both banks occupied, third frame dropped
  task automatic test_overrun();
    logic [PW-1:0] held;
    rx_cnt = 0; drop_cnt = 0; ready_mode = 2;
    send_frame(4, WPL, 0);
    send_frame(5, WPL, 0);
    repeat (3) tick();
    @(negedge clk);
    held = out_data;
    check(out_valid && out_sof, "R9", "stalled first word presented", out_valid, 1);
    send_frame(6, WPL, 0);
    repeat (3) tick();
    check(drop_cnt == 1, "R7", "drop pulses for third frame", drop_cnt, 1);
    @(negedge clk);
    check(out_data == held && out_valid, "R9", "word held while stalled", out_data, held);
    ready_mode = 0;
    wait_words(2 * FP);
    check_frame(4, 0);
    check_frame(5, FP);
    repeat (40) tick();
    check(rx_cnt == 2 * FP, "R7", "dropped frame never drained", rx_cnt, 2 * FP);
  endtask

  // R10: bank held until its last word is accepted
  task automatic test_release();
    rx_cnt = 0; drop_cnt = 0; ready_mode = 3; out_ready = 1'b0;
    send_frame(8, WPL, 0);
    send_frame(9, WPL, 0);
    tick();
    out_ready = 1'b1;
    repeat (FP - 1) @(posedge clk);
    #1 out_ready = 1'b0;
    tick();
    check(rx_cnt == FP - 1, "R10", "handshakes before last word", rx_cnt, FP - 1);
    check(rx_eof[FP-2] == 1'b0, "R8", "no eof before last word", rx_eof[FP-2], 0);
    send_frame(10, WPL, 0);
    repeat (3) tick();
    check(drop_cnt == 1, "R10", "frame dropped while last word pending", drop_cnt, 1);
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    tick();
    check(rx_cnt == FP, "R10", "last word accepted", rx_cnt, FP);
    send_frame(10, WPL, 0);
    repeat (3) tick();
    check(drop_cnt == 1, "R10", "frame accepted after release", drop_cnt, 1);
    ready_mode = 0;
    wait_words(3 * FP);
    check_frame(8, 0);
    check_frame(9, FP);
    check_frame(10, 2 * FP);
  endtask

  // R4, R5: restart mid-frame, stray bits outside a frame
  task automatic test_restart();
    rx_cnt = 0; drop_cnt = 0; ready_mode = 0;
    send_frame(11, 2, 0);
    send_frame(12, WPL, 0);
    wait_words(FP);
    check_frame(12, 0);
    for (int i = 0; i < 5 * PW * WPL; i++) begin
      in_valid  = 1'b1;
      lane_bits = $urandom;
      tick();
    end
    in_valid = 1'b0;
    repeat (40) tick();
    check(rx_cnt == FP, "R5", "stray bits after complete frame ignored", rx_cnt, FP);
    check(drop_cnt == 0, "R4", "restart causes no drop", drop_cnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0;
    lane_bits = '0; out_ready = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    repeat (4) tick();
    test_single();
    test_overlap();
    test_overrun();
    test_release();
    test_restart();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule